// File: doc/BRIEF.md
# FIFO Control and Interrupt Status Unit

This unit is the register face of a serial controller's word FIFOs. A simple register bus reaches a control register, a FIFO level word, an interrupt status register and an interrupt mask. Two more addresses act as data ports: a write to one pushes a word toward the transmit FIFO and a read from the other pops the head of the receive FIFO. The FIFO arrays and the serial engine live outside the unit. They report their occupancy levels and flush completion, and the engine raises single-cycle event pulses.

Software starts a flush of either FIFO by setting a control bit. The bit reads back as 1 until the FIFO acknowledges, so software can poll it. Two programmable trigger levels produce data-request events. These join engine events and port misuse events (a push into a full transmit FIFO, a pop from an empty receive FIFO) in a write-one-to-clear status register. The interrupt output combines that register with the mask. The packet-complete event always reaches the interrupt, whatever the mask holds.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is asserted, the control register (address 0), the status register (address 2) and the mask register (address 3) read 0, and the interrupt output and both flush request outputs are low.
- R2: A read of address 1 returns the transmit free space (DEPTH minus transmit occupancy) in bits 7:4 and the receive occupancy in bits 3:0.
- R3: Writing 1 to bit 1 (transmit) or bit 0 (receive) of address 0 starts a flush. From then on that bit reads 1 and the matching flush request output is high. Writing 0 does not clear it. It clears on the clock edge at which the matching acknowledge input is high.
- R4: Bits 7:5 of address 0 hold the transmit trigger level and bits 4:2 hold the receive trigger level. Both are written and read back at those positions.
- R5: Status bit 1 is set on every clock edge at which transmit free space is at or above the transmit trigger. Status bit 0 is set on every edge at which receive occupancy is strictly above the receive trigger.
- R6: Writing address 2 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When an event and a clearing write of the same status bit fall in one cycle, the bit stays set.
- R8: A write to address 4 while transmit occupancy equals DEPTH raises no push, drops the word and sets status bit 5. Otherwise the write pushes the word to the transmit FIFO.
- R9: A read of address 5 while receive occupancy is 0 returns 0, raises no pop and sets status bit 4. Otherwise it pops and returns the head word.
- R10: The engine pulses for packet complete, all packets complete, no-acknowledge and arbitration lost set status bits 7, 6, 3 and 2 respectively.
- R11: The interrupt output is high exactly when some status bit is set whose mask bit is 1, or when status bit 7 is set, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| tx_level_i | input | 4 | Transmit FIFO occupancy in words |
| tx_push_o | output | 1 | Push strobe to the transmit FIFO |
| tx_word_o | output | 32 | Word to push |
| tx_flush_o | output | 1 | Transmit flush request, held until acknowledged |
| tx_flush_ack_i | input | 1 | Transmit flush completed |
| rx_level_i | input | 4 | Receive FIFO occupancy in words |
| rx_pop_o | output | 1 | Pop strobe to the receive FIFO |
| rx_word_i | input | 32 | Head word of the receive FIFO |
| rx_flush_o | output | 1 | Receive flush request, held until acknowledged |
| rx_flush_ack_i | input | 1 | Receive flush completed |
| ev_pkt_done_i | input | 1 | Packet complete pulse |
| ev_all_done_i | input | 1 | All packets complete pulse |
| ev_nack_i | input | 1 | No-acknowledge pulse |
| ev_arb_lost_i | input | 1 | Arbitration lost pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the FIFO levels never exceed DEPTH and that a flush acknowledge arrives only while the matching flush request is high. They also assume that read and write strobes are never raised in the same cycle. The bench keeps to these rules. It sets the levels directly to values between 0 and DEPTH, and it pulses each acknowledge only after the flush request has been checked high. Its register tasks raise a single strobe per access. Engine events are pulses one cycle long, driven at the falling edge and dropped at the next falling edge.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int ADDR_W = 3;
  localparam int ST_W   = 8;

  // status bit positions
  localparam int ST_PKT   = 7;
  localparam int ST_ALL   = 6;
  localparam int ST_OVF   = 5;
  localparam int ST_UNF   = 4;
  localparam int ST_NACK  = 3;
  localparam int ST_ARB   = 2;
  localparam int ST_TXREQ = 1;
  localparam int ST_RXREQ = 0;

  // flush bit positions in the control register (also generate index)
  localparam int FL_RX = 0;
  localparam int FL_TX = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_LEVEL = 3'd1,
    A_STAT  = 3'd2,
    A_MASK  = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5
  } reg_addr_e;

  function automatic int words_free(int depth, int level);
    return depth - level;
  endfunction

  function automatic logic tx_wants(int free_words, int trig);
    return free_words >= trig;
  endfunction

  function automatic logic rx_wants(int level, int trig);
    return level > trig;
  endfunction

endpackage

// File: rtl/fcs_flush_ctl.sv
module fcs_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o
);

  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (ack_i)   busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  // R3: a pending flush survives any cycle without acknowledge
  a_r3_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_i) |=> busy_q);

  // R3: acknowledge ends the flush unless a new one starts
  a_r3_flush_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ack_i && !start_i) |=> !busy_q);

endmodule

// File: rtl/fcs_data_port.sv
module fcs_data_port #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tx_i,
  input  logic              rd_rx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  tx_level_i,
  input  logic [CNT_W-1:0]  rx_level_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              rx_pop_o,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              ovf_ev_o,
  output logic              unf_ev_o
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic tx_full;
  logic rx_empty;

  assign tx_full  = (tx_level_i >= FULL_LVL);
  assign rx_empty = (rx_level_i == '0);

  assign tx_push_o = wr_tx_i & ~tx_full;
  assign ovf_ev_o  = wr_tx_i &  tx_full;
  assign tx_word_o = wdata_i;

  assign rx_pop_o  = rd_rx_i & ~rx_empty;
  assign unf_ev_o  = rd_rx_i &  rx_empty;
  assign rd_word_o = rx_empty ? '0 : rx_word_i;

  // R8: a full transmit FIFO never receives a push
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level_i == FULL_LVL) |-> !tx_push_o);

  // R9: an empty receive FIFO is never popped
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_i == '0) |-> !rx_pop_o);

endmodule

// File: rtl/fcs_evt_latch.sv
module fcs_evt_latch
  import fcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] ev_i,
  input  logic [ST_W-1:0] w1c_i,
  input  logic [ST_W-1:0] mask_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);

  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~w1c_i) | ev_i;
  end

  always_comb begin
    enable         = mask_i;
    enable[ST_PKT] = 1'b1;
  end

  assign irq_o  = |(stat_q & enable);
  assign stat_o = stat_q;

  for (genvar b = 0; b < ST_W; b++) begin : g_bit_chk
    // R7: an event sets its bit even against a clearing write
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[b] |=> stat_q[b]);
    // R6: a clearing write without an event empties the bit
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_i[b] && !ev_i[b]) |=> !stat_q[b]);
  end

  // R11: packet completion always reaches the interrupt
  a_r11_pkt_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ST_PKT] |-> irq_o);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fcs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CNT_W-1:0]  tx_level_i,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_flush_o,
  input  logic              tx_flush_ack_i,
  input  logic [CNT_W-1:0]  rx_level_i,
  output logic              rx_pop_o,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              rx_flush_o,
  input  logic              rx_flush_ack_i,
  input  logic              ev_pkt_done_i,
  input  logic              ev_all_done_i,
  input  logic              ev_nack_i,
  input  logic              ev_arb_lost_i,
  output logic              irq_o
);

  localparam int TRIG_W      = $clog2(DEPTH);
  localparam int RXTRIG_LSB  = 2;
  localparam int TXTRIG_LSB  = RXTRIG_LSB + TRIG_W;
  localparam int N_FIFO      = 2;

  // decoded strobes
  logic wr_ctrl, wr_stat, wr_mask, wr_txd, rd_rxd;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_mask = reg_wr_i && (reg_addr_i == A_MASK);
  assign wr_txd  = reg_wr_i && (reg_addr_i == A_TXD);
  assign rd_rxd  = reg_rd_i && (reg_addr_i == A_RXD);

  // configuration registers
  logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
  logic [ST_W-1:0]   mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig_q <= '0;
      rx_trig_q <= '0;
      mask_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_trig_q <= reg_wdata_i[TXTRIG_LSB +: TRIG_W];
        rx_trig_q <= reg_wdata_i[RXTRIG_LSB +: TRIG_W];
      end
      if (wr_mask) mask_q <= reg_wdata_i[ST_W-1:0];
    end
  end

  // flush sequencing: index equals the control bit position
  logic [N_FIFO-1:0] fl_start, fl_ack, fl_busy;

  assign fl_ack[FL_RX] = rx_flush_ack_i;
  assign fl_ack[FL_TX] = tx_flush_ack_i;

  for (genvar k = 0; k < N_FIFO; k++) begin : g_flush
    assign fl_start[k] = wr_ctrl & reg_wdata_i[k];
    fcs_flush_ctl i_flush (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (fl_start[k]),
      .ack_i   (fl_ack[k]),
      .busy_o  (fl_busy[k])
    );
  end

  assign tx_flush_o = fl_busy[FL_TX];
  assign rx_flush_o = fl_busy[FL_RX];

  // data ports
  logic              ovf_ev, unf_ev;
  logic [DATA_W-1:0] rx_rd_word;

  fcs_data_port #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) i_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_tx_i    (wr_txd),
    .rd_rx_i    (rd_rxd),
    .wdata_i    (reg_wdata_i),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .rx_word_i  (rx_word_i),
    .tx_push_o  (tx_push_o),
    .tx_word_o  (tx_word_o),
    .rx_pop_o   (rx_pop_o),
    .rd_word_o  (rx_rd_word),
    .ovf_ev_o   (ovf_ev),
    .unf_ev_o   (unf_ev)
  );

  // threshold comparison
  logic [CNT_W-1:0] tx_free;
  logic             tx_req, rx_req;

  assign tx_free = CNT_W'(words_free(DEPTH, int'(tx_level_i)));
  assign tx_req  = tx_wants(int'(tx_free), int'(tx_trig_q));
  assign rx_req  = rx_wants(int'(rx_level_i), int'(rx_trig_q));

  // event collection
  logic [ST_W-1:0] events, w1c, stat;

  always_comb begin
    events           = '0;
    events[ST_PKT]   = ev_pkt_done_i;
    events[ST_ALL]   = ev_all_done_i;
    events[ST_OVF]   = ovf_ev;
    events[ST_UNF]   = unf_ev;
    events[ST_NACK]  = ev_nack_i;
    events[ST_ARB]   = ev_arb_lost_i;
    events[ST_TXREQ] = tx_req;
    events[ST_RXREQ] = rx_req;
  end

  assign w1c = wr_stat ? reg_wdata_i[ST_W-1:0] : '0;

  fcs_evt_latch i_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (events),
    .w1c_i  (w1c),
    .mask_i (mask_q),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[TXTRIG_LSB +: TRIG_W] = tx_trig_q;
        reg_rdata_o[RXTRIG_LSB +: TRIG_W] = rx_trig_q;
        reg_rdata_o[FL_TX]                = fl_busy[FL_TX];
        reg_rdata_o[FL_RX]                = fl_busy[FL_RX];
      end
      A_LEVEL: begin
        reg_rdata_o[CNT_W +: CNT_W] = tx_free;
        reg_rdata_o[0 +: CNT_W]     = rx_level_i;
      end
      A_STAT:  reg_rdata_o[ST_W-1:0] = stat;
      A_MASK:  reg_rdata_o[ST_W-1:0] = mask_q;
      A_RXD:   reg_rdata_o = rx_rd_word;
      default: reg_rdata_o = '0;
    endcase
  end

  // R5: a held transmit request shows in status one edge later
  a_r5_txreq_latched: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> stat[ST_TXREQ]);

endmodule

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [CNT_W-1:0]  tx_level = '0, rx_level = '0;
  logic              tx_push, rx_pop, tx_flush, rx_flush, irq;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word = '0;
  logic              tx_ack = 1'b0, rx_ack = 1'b0;
  logic              ev_pkt = 1'b0, ev_all = 1'b0, ev_nack = 1'b0, ev_arb = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic              seen_push, seen_pop;
  logic [DATA_W-1:0] seen_word;

  always #4 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_level_i(tx_level), .tx_push_o(tx_push), .tx_word_o(tx_word),
    .tx_flush_o(tx_flush), .tx_flush_ack_i(tx_ack),
    .rx_level_i(rx_level), .rx_pop_o(rx_pop), .rx_word_i(rx_word),
    .rx_flush_o(rx_flush), .rx_flush_ack_i(rx_ack),
    .ev_pkt_done_i(ev_pkt), .ev_all_done_i(ev_all),
    .ev_nack_i(ev_nack), .ev_arb_lost_i(ev_arb), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    seen_push = tx_push; seen_word = tx_word;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata; seen_pop = rx_pop;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(3'd0, v); chk("R1 ctrl", v, 32'h0);
    peek(3'd2, v); chk("R1 status", v, 32'h0);
    peek(3'd3, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 flush outs", {30'b0, tx_flush, rx_flush}, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    @(negedge clk); tx_level = 4'd3; rx_level = 4'd5;
    peek(3'd1, v); chk("R2 levels 3/5", v, 32'h55);
    @(negedge clk); tx_level = 4'd8; rx_level = 4'd0;
    peek(3'd1, v); chk("R2 tx full", v, 32'h00);
    @(negedge clk); tx_level = 4'd0; rx_level = 4'd8;
    peek(3'd1, v); chk("R2 rx full", v, 32'h88);
    @(negedge clk); tx_level = 4'd0; rx_level = 4'd0;
  endtask

  task automatic t_triggers();
    logic [31:0] v;
    wr_reg(3'd0, 32'h88);
    rd_reg(3'd0, v); chk("R4 trig readback", v, 32'h88);
    @(negedge clk); tx_level = 4'd4; rx_level = 4'd2;
    wr_reg(3'd2, 32'hFF);
    rd_reg(3'd2, v); chk("R5 tx free at trig", v & 32'h3, 32'h2);
    @(negedge clk); tx_level = 4'd5;
    wr_reg(3'd2, 32'hFF);
    rd_reg(3'd2, v); chk("R5 below trig", v & 32'h3, 32'h0);
    @(negedge clk); rx_level = 4'd3;
    @(negedge clk);
    rd_reg(3'd2, v); chk("R5 rx above trig", v & 32'h3, 32'h1);
    chk("R11 masked off", {31'b0, irq}, 32'h0);
    wr_reg(3'd3, 32'h01);
    chk("R11 mask enables", {31'b0, irq}, 32'h1);
    rd_reg(3'd3, v); chk("R11 mask readback", v, 32'h01);
    @(negedge clk); rx_level = 4'd2;
    wr_reg(3'd2, 32'h01);
    chk("R11 cleared", {31'b0, irq}, 32'h0);
    wr_reg(3'd3, 32'h00);
  endtask

  task automatic t_engine();
    logic [31:0] v;
    @(negedge clk); ev_pkt = 1'b1;
    @(negedge clk); ev_pkt = 1'b0;
    rd_reg(3'd2, v); chk("R10 pkt bit", v, 32'h80);
    chk("R11 pkt ignores mask", {31'b0, irq}, 32'h1);
    wr_reg(3'd2, 32'h80);
    rd_reg(3'd2, v); chk("R6 pkt cleared", v, 32'h00);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk); ev_all = 1'b1; ev_nack = 1'b1; ev_arb = 1'b1;
    @(negedge clk); ev_all = 1'b0; ev_nack = 1'b0; ev_arb = 1'b0;
    rd_reg(3'd2, v); chk("R10 all/nack/arb", v, 32'h4C);
    chk("R11 masked events", {31'b0, irq}, 32'h0);
    wr_reg(3'd2, 32'h4C);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk);
    ev_nack = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h08;
    @(negedge clk);
    ev_nack = 1'b0; reg_wr = 1'b0;
    rd_reg(3'd2, v); chk("R7 event beats clear", v, 32'h08);
    wr_reg(3'd2, 32'h00);
    rd_reg(3'd2, v); chk("R6 zero write keeps", v, 32'h08);
    wr_reg(3'd2, 32'h08);
    rd_reg(3'd2, v); chk("R6 one write clears", v, 32'h00);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    @(negedge clk); tx_level = 4'd8;
    wr_reg(3'd4, 32'h1234);
    chk("R8 no push when full", {31'b0, seen_push}, 32'h0);
    rd_reg(3'd2, v); chk("R8 overflow bit", v, 32'h20);
    @(negedge clk); tx_level = 4'd7;
    wr_reg(3'd4, 32'hCAFE);
    chk("R8 push when room", {31'b0, seen_push}, 32'h1);
    chk("R8 pushed word", seen_word, 32'hCAFE);
    rd_reg(3'd2, v); chk("R8 no new overflow", v, 32'h20);
    wr_reg(3'd2, 32'h20);
    @(negedge clk); tx_level = 4'd5;
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    @(negedge clk); rx_level = 4'd0; rx_word = 32'hDEAD_BEEF;
    rd_reg(3'd5, v);
    chk("R9 empty reads zero", v, 32'h0);
    chk("R9 no pop when empty", {31'b0, seen_pop}, 32'h0);
    rd_reg(3'd2, v); chk("R9 underflow bit", v, 32'h10);
    @(negedge clk); rx_level = 4'd2; rx_word = 32'hA5A5_0001;
    rd_reg(3'd5, v);
    chk("R9 head word", v, 32'hA5A5_0001);
    chk("R9 pop", {31'b0, seen_pop}, 32'h1);
    rd_reg(3'd2, v); chk("R9 no new underflow", v, 32'h10);
    wr_reg(3'd2, 32'h10);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    wr_reg(3'd0, 32'h8A);
    rd_reg(3'd0, v); chk("R3 tx flush pending", v, 32'h8A);
    chk("R3 flush outs", {30'b0, tx_flush, rx_flush}, 32'h2);
    wr_reg(3'd0, 32'h88);
    repeat (3) @(negedge clk);
    rd_reg(3'd0, v); chk("R3 zero write no cancel", v, 32'h8A);
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
    rd_reg(3'd0, v); chk("R3 tx flush done", v, 32'h88);
    chk("R3 tx request dropped", {31'b0, tx_flush}, 32'h0);
    wr_reg(3'd0, 32'h89);
    chk("R3 rx request", {30'b0, tx_flush, rx_flush}, 32'h1);
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    rd_reg(3'd0, v); chk("R3 rx flush done", v, 32'h88);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_levels();
    t_triggers();
    t_engine();
    t_collision();
    t_overflow();
    t_underflow();
    t_flush();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule